// File: doc/BRIEF.md
# Remote DMA Command and Channel Controller

This block holds the command byte of a local-bus Ethernet MAC and runs the remote DMA channel that the byte controls. The host writes the command at register offset 0. That one write selects the register page, starts or aborts a remote read or remote write, requests a packet transmit, and starts or stops the controller. The command reads back with the transfer field that the hardware keeps up to date.

Before a transfer starts, software loads a 16-bit current address and a 16-bit byte count. During a remote write, each byte that the host writes to the data port goes into the buffer at the current address. During a remote read, each read of the data port returns the buffer byte at the current address. Every moved byte advances the address by one and lowers the count by one. When the count reaches zero, the hardware sets the transfer field to the complete code and pulses a completion output. The buffer RAM is outside the block and is reached through a memory port whose read data is combinational.

Top module: `rdma_cmd_ctrl`

## Requirements
- R1: After reset the page output is 0, the controller is stopped, no transfer is active, `tx_req` and `rdma_done` are low, and the command reads back as 0x21.
- R2: Command bits 7:6 drive `page_sel`. Address and count registers are reached only while the page is 00. On any other page, writes to them are dropped and reads return 0.
- R3: Command bit 1 sets the running flag and bit 0 clears it. When both bits are set in one write, bit 0 wins. Readback bit 1 is the running flag and bit 0 is its inverse.
- R4: A command write with bit 2 set, while the controller is running after that write, raises `tx_req` for exactly the next cycle. Bit 2 always reads back 0. When the controller is stopped, bit 2 has no effect.
- R5: Transfer field bits 5:3 set to 001 start a remote read and 010 start a remote write. The start is accepted only when the controller is running after that write and no transfer is active. Otherwise the write leaves the transfer state and the field unchanged.
- R6: During a transfer, each data port access (offset 0x10) moves one byte through the memory port at the current address. The address then increases by 1 and the count decreases by 1. Bytes read this way appear on `host_rdata`.
- R7: When the count reaches zero, the transfer ends and the field reads 100 with no software write. `rdma_done` is high for exactly one cycle. A transfer started with a count of zero completes at once.
- R8: A field value of 1xx aborts any transfer. The count becomes 0, the current address keeps the value it had reached, and `rdma_done` stays low.
- R9: Field values 000 and 011 do not change the transfer state or the stored field.
- R10: A data port access while no transfer is active makes no memory access, and a read of the data port returns 0.
- R11: The address bytes sit at offsets 8 (low) and 9 (high), and the count bytes at 10 (low) and 11 (high). They read back the live values. Writes to them are dropped while a transfer is active. `host_rdata` is registered: it updates in the cycle after `host_rd` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 5 | Register offset of the host access |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| page_sel | output | 2 | Selected register page |
| running | output | 1 | Controller running flag |
| tx_req | output | 1 | One-cycle packet transmit request |
| rdma_busy | output | 1 | Remote transfer active |
| rdma_done | output | 1 | One-cycle remote transfer completion pulse |
| mem_addr | output | 16 | Buffer address |
| mem_we | output | 1 | Buffer write enable |
| mem_re | output | 1 | Buffer read enable |
| mem_wdata | output | 8 | Buffer write data |
| mem_rdata | input | 8 | Buffer read data, combinational |

## Verification
The hardest states to reach from the ports are an abort that arrives partway through a transfer and a completion triggered by the last byte. Both need a started controller, loaded address and count registers, and a partial run of data port accesses on the correct page. The stimulus loads a short count, moves some of the bytes, and then either aborts or finishes. It reads the address and count back through the register offsets and checks that the address was kept where it stopped. It also sends illegal and conflicting commands in the middle of a transfer, then reads the command back to show the field was not changed.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_READ  = 2'd1,
        XF_WRITE = 2'd2
    } xfer_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_ABORT = 2'd3
    } op_e;

    // register offsets
    localparam int unsigned OFS_CMD   = 0;
    localparam int unsigned OFS_ADDR0 = 8;
    localparam int unsigned OFS_CNT0  = 10;
    localparam int unsigned OFS_DATA  = 16;

    // transfer field codes
    localparam logic [2:0] FLD_READ  = 3'b001;
    localparam logic [2:0] FLD_WRITE = 3'b010;
    localparam logic [2:0] FLD_DONE  = 3'b100;

endpackage

// File: rtl/rdma_cmd_reg.sv
module rdma_cmd_reg
    import rdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] wdata,
    input  logic       busy,
    input  logic       fin_now,
    output logic       start_xfer,
    output logic       start_is_wr,
    output logic       abort_now,
    output logic [1:0] page_q_o,
    output logic       run_q_o,
    output logic       tx_q_o,
    output logic       done_q_o,
    output logic [7:0] cmd_rb
);

    typedef struct packed {
        logic [1:0] page;
        logic [2:0] field;
        logic       run;
        logic       tx;
        logic       done;
    } cmd_st_t;

    cmd_st_t st_d, st_q;
    op_e     op;
    logic    run_n;

    always_comb begin
        if (wdata[5])
            op = OP_ABORT;
        else if (wdata[4:3] == 2'b01)
            op = OP_READ;
        else if (wdata[4:3] == 2'b10)
            op = OP_WRITE;
        else
            op = OP_NONE;

        run_n = st_q.run;
        if (cmd_wr) begin
            if (wdata[0])
                run_n = 1'b0;
            else if (wdata[1])
                run_n = 1'b1;
        end

        start_xfer  = cmd_wr && (op == OP_READ || op == OP_WRITE) && run_n && !busy;
        start_is_wr = (op == OP_WRITE);
        abort_now   = cmd_wr && (op == OP_ABORT);

        st_d      = st_q;
        st_d.run  = run_n;
        st_d.tx   = cmd_wr && wdata[2] && run_n;
        st_d.done = fin_now;
        if (cmd_wr)
            st_d.page = wdata[7:6];
        if (start_xfer || abort_now)
            st_d.field = wdata[5:3];
        if (fin_now)
            st_d.field = FLD_DONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.page  <= 2'b00;
            st_q.field <= FLD_DONE;
            st_q.run   <= 1'b0;
            st_q.tx    <= 1'b0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page_q_o = st_q.page;
    assign run_q_o  = st_q.run;
    assign tx_q_o   = st_q.tx;
    assign done_q_o = st_q.done;
    assign cmd_rb   = {st_q.page, st_q.field, 1'b0, st_q.run, ~st_q.run};

    AST_TX_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tx |-> $past(cmd_wr) && $past(wdata[2])); // R4
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wdata[0] |=> !st_q.run); // R3
    AST_DONE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> st_q.field == FLD_DONE); // R7

endmodule

// File: rtl/rdma_channel.sv
module rdma_channel
    import rdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned AB    = ADDR_W / 8,
    localparam int unsigned CB    = CNT_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_xfer,
    input  logic              start_is_wr,
    input  logic              abort_now,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [AB-1:0]     addr_wmask,
    input  logic [CB-1:0]     cnt_wmask,
    input  logic [7:0]        wdata,
    output logic              busy,
    output logic              fin_now,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        data_rb
);

    typedef struct packed {
        xfer_e             state;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } ch_st_t;

    ch_st_t ch_d, ch_q;
    logic   access;
    logic   last_byte;

    always_comb begin
        mem_we    = data_wr && (ch_q.state == XF_WRITE);
        mem_re    = data_rd && (ch_q.state == XF_READ);
        access    = mem_we || mem_re;
        last_byte = (ch_q.cnt == CNT_W'(1));
        fin_now   = (access && last_byte) || (start_xfer && ch_q.cnt == '0);

        ch_d = ch_q;
        if (abort_now) begin
            ch_d.state = XF_IDLE;
            ch_d.cnt   = '0;
        end else if (start_xfer) begin
            if (ch_q.cnt == '0)
                ch_d.state = XF_IDLE;
            else
                ch_d.state = start_is_wr ? XF_WRITE : XF_READ;
        end else if (access) begin
            ch_d.addr = ch_q.addr + 1'b1;
            ch_d.cnt  = ch_q.cnt - 1'b1;
            if (last_byte)
                ch_d.state = XF_IDLE;
        end else if (ch_q.state == XF_IDLE) begin
            for (int i = 0; i < AB; i++)
                if (addr_wmask[i])
                    ch_d.addr[8*i +: 8] = wdata;
            for (int i = 0; i < CB; i++)
                if (cnt_wmask[i])
                    ch_d.cnt[8*i +: 8] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q.state <= XF_IDLE;
            ch_q.addr  <= '0;
            ch_q.cnt   <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign busy      = (ch_q.state != XF_IDLE);
    assign cur_addr  = ch_q.addr;
    assign cur_cnt   = ch_q.cnt;
    assign mem_addr  = ch_q.addr;
    assign mem_wdata = wdata;
    assign data_rb   = mem_re ? mem_rdata : 8'h00;

    AST_ABORT_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        abort_now |=> cur_cnt == '0); // R8
    AST_ABORT_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        abort_now |=> $stable(cur_addr)); // R8
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |=> cur_addr == $past(cur_addr) + 1'b1); // R6
    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we && !mem_re); // R10
    AST_BUSY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cur_cnt != '0); // R7

endmodule

// File: rtl/rdma_cmd_ctrl.sv
module rdma_cmd_ctrl
    import rdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned OFS_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [1:0]        page_sel,
    output logic              running,
    output logic              tx_req,
    output logic              rdma_busy,
    output logic              rdma_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    localparam int unsigned AB = ADDR_W / 8;
    localparam int unsigned CB = CNT_W / 8;

    logic              cmd_wr, data_wr, data_rd, page0;
    logic              start_xfer, start_is_wr, abort_now, busy, fin_now;
    logic [AB-1:0]     addr_wmask;
    logic [CB-1:0]     cnt_wmask;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_cnt;
    logic [7:0]        cmd_rb, data_rb;
    logic [7:0]        rdata_d, rdata_q;

    assign cmd_wr  = host_wr && (host_addr == OFS_W'(OFS_CMD));
    assign data_wr = host_wr && (host_addr == OFS_W'(OFS_DATA));
    assign data_rd = host_rd && (host_addr == OFS_W'(OFS_DATA));
    assign page0   = (page_sel == 2'b00);

    for (genvar g = 0; g < AB; g++) begin : g_addr_sel
        assign addr_wmask[g] = host_wr && page0 && (host_addr == OFS_W'(OFS_ADDR0 + g));
    end
    for (genvar g = 0; g < CB; g++) begin : g_cnt_sel
        assign cnt_wmask[g] = host_wr && page0 && (host_addr == OFS_W'(OFS_CNT0 + g));
    end

    rdma_cmd_reg u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .wdata       (host_wdata),
        .busy        (busy),
        .fin_now     (fin_now),
        .start_xfer  (start_xfer),
        .start_is_wr (start_is_wr),
        .abort_now   (abort_now),
        .page_q_o    (page_sel),
        .run_q_o     (running),
        .tx_q_o      (tx_req),
        .done_q_o    (rdma_done),
        .cmd_rb      (cmd_rb)
    );

    rdma_channel #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_chan (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_xfer  (start_xfer),
        .start_is_wr (start_is_wr),
        .abort_now   (abort_now),
        .data_wr     (data_wr),
        .data_rd     (data_rd),
        .addr_wmask  (addr_wmask),
        .cnt_wmask   (cnt_wmask),
        .wdata       (host_wdata),
        .busy        (busy),
        .fin_now     (fin_now),
        .cur_addr    (cur_addr),
        .cur_cnt     (cur_cnt),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_re      (mem_re),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .data_rb     (data_rb)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (host_rd) begin
            rdata_d = 8'h00;
            if (host_addr == OFS_W'(OFS_CMD))
                rdata_d = cmd_rb;
            if (host_addr == OFS_W'(OFS_DATA))
                rdata_d = data_rb;
            for (int i = 0; i < AB; i++)
                if (page0 && host_addr == OFS_W'(OFS_ADDR0 + i))
                    rdata_d = cur_addr[8*i +: 8];
            for (int i = 0; i < CB; i++)
                if (page0 && host_addr == OFS_W'(OFS_CNT0 + i))
                    rdata_d = cur_cnt[8*i +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= 8'h00;
        else
            rdata_q <= rdata_d;
    end

    assign host_rdata = rdata_q;
    assign rdma_busy  = busy;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata)); // R11
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rdma_done |-> !rdma_busy); // R7

endmodule

// File: tb/sim_rdma_cmd_ctrl.sv
module sim_rdma_cmd_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [1:0]  page_sel;
    logic        running, tx_req, rdma_busy, rdma_done;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0]  mem [256];
    int          n_chk = 0;
    int          n_fail = 0;
    logic        rd_seen = 1'b0;
    logic        finished = 1'b0;
    logic [7:0]  exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    rdma_cmd_ctrl u0 (
        .clk (clk), .rst_n (rst_n), .host_addr (host_addr), .host_wr (host_wr),
        .host_rd (host_rd), .host_wdata (host_wdata), .host_rdata (host_rdata),
        .page_sel (page_sel), .running (running), .tx_req (tx_req),
        .rdma_busy (rdma_busy), .rdma_done (rdma_done), .mem_addr (mem_addr),
        .mem_we (mem_we), .mem_re (mem_re), .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // buffer model
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[7:0]];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // driver: issue a read and push its expected value to the scoreboard
    task automatic rd_exp(input logic [4:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // monitor
    always @(posedge clk) rd_seen <= host_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, int'(host_rdata), int'(e));
        end
    end

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 page", int'(page_sel), 0);
        chk("R1 running", int'(running), 0);
        chk("R1 busy", int'(rdma_busy), 0);
        chk("R1 tx_req", int'(tx_req), 0);
        chk("R1 done", int'(rdma_done), 0);
        rd_exp(5'd0, 8'h21, "R1 cmd readback");

        // R3 start; R9 code 000 leaves field at 100
        wr(5'd0, 8'h02);
        chk("R3 running", int'(running), 1);
        rd_exp(5'd0, 8'h22, "R3 R9 cmd readback");

        // R4 transmit pulse
        wr(5'd0, 8'h06);
        chk("R4 tx_req high", int'(tx_req), 1);
        @(negedge clk);
        chk("R4 tx_req one cycle", int'(tx_req), 0);
        rd_exp(5'd0, 8'h22, "R4 bit2 reads 0");

        // R11 address and count registers
        wr(5'd8, 8'h40); wr(5'd9, 8'h00); wr(5'd10, 8'h03); wr(5'd11, 8'h00);
        rd_exp(5'd8, 8'h40, "R11 addr lo");
        rd_exp(5'd10, 8'h03, "R11 cnt lo");

        // R2 page gating
        wr(5'd0, 8'h42);
        chk("R2 page_sel", int'(page_sel), 1);
        wr(5'd8, 8'h99);
        rd_exp(5'd8, 8'h00, "R2 page1 read zero");
        wr(5'd0, 8'h02);
        rd_exp(5'd8, 8'h40, "R2 page1 write dropped");

        // R5 R6 remote write
        wr(5'd0, 8'h12);
        chk("R5 busy after write cmd", int'(rdma_busy), 1);
        rd_exp(5'd0, 8'h12, "R5 field write code");
        wr(5'd16, 8'hA1);
        wr(5'd16, 8'hA2);
        chk("R6 mem 0x40", int'(mem[8'h40]), 8'hA1);
        chk("R6 mem 0x41", int'(mem[8'h41]), 8'hA2);
        rd_exp(5'd8, 8'h42, "R6 addr advanced");
        rd_exp(5'd10, 8'h01, "R6 cnt lowered");
        wr(5'd8, 8'h77);
        rd_exp(5'd8, 8'h42, "R11 write dropped while busy");
        wr(5'd0, 8'h1A);
        chk("R9 busy kept", int'(rdma_busy), 1);
        rd_exp(5'd0, 8'h12, "R9 field kept");
        wr(5'd16, 8'hA3);
        chk("R7 done pulse", int'(rdma_done), 1);
        chk("R7 busy cleared", int'(rdma_busy), 0);
        @(negedge clk);
        chk("R7 done one cycle", int'(rdma_done), 0);
        chk("R6 mem 0x42", int'(mem[8'h42]), 8'hA3);
        rd_exp(5'd0, 8'h22, "R7 field complete");

        // R10 idle data port
        wr(5'd16, 8'h55);
        chk("R10 no mem write", int'(mem[8'h43]), 0);
        rd_exp(5'd16, 8'h00, "R10 idle read zero");

        // R6 remote read
        wr(5'd8, 8'h40); wr(5'd10, 8'h02);
        wr(5'd0, 8'h0A);
        chk("R5 busy after read cmd", int'(rdma_busy), 1);
        rd_exp(5'd16, 8'hA1, "R6 read byte 0");
        rd_exp(5'd16, 8'hA2, "R6 read byte 1");
        chk("R7 read done pulse", int'(rdma_done), 1);

        // R8 abort mid-transfer
        wr(5'd8, 8'h40); wr(5'd10, 8'h03);
        wr(5'd0, 8'h12);
        wr(5'd16, 8'hB1);
        wr(5'd0, 8'h22);
        chk("R8 busy cleared", int'(rdma_busy), 0);
        chk("R8 no done", int'(rdma_done), 0);
        rd_exp(5'd10, 8'h00, "R8 cnt lo zero");
        rd_exp(5'd11, 8'h00, "R8 cnt hi zero");
        rd_exp(5'd8, 8'h41, "R8 addr kept");

        // R7 zero-count start completes at once
        wr(5'd0, 8'h12);
        chk("R7 zero count done", int'(rdma_done), 1);
        chk("R7 zero count idle", int'(rdma_busy), 0);

        // R3 R4 R5 stopped controller
        wr(5'd0, 8'h01);
        rd_exp(5'd0, 8'h21, "R3 stop readback");
        wr(5'd10, 8'h02);
        wr(5'd0, 8'h11);
        chk("R5 no start when stopped", int'(rdma_busy), 0);
        wr(5'd0, 8'h05);
        chk("R4 no tx when stopped", int'(tx_req), 0);
        wr(5'd0, 8'h02);
        wr(5'd0, 8'h03);
        chk("R3 stop wins", int'(running), 0);

        // R5 new transfer command ignored while busy
        wr(5'd0, 8'h12);
        chk("R5 busy", int'(rdma_busy), 1);
        wr(5'd0, 8'h0A);
        rd_exp(5'd0, 8'h12, "R5 second start ignored");
        wr(5'd0, 8'h22);
        rd_exp(5'd10, 8'h00, "R8 abort cnt");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        summary();
    end

endmodule